// File: doc/BRIEF.md
# Two-Write Packet Assembler Queue

This block sits between a small 8-bit processor and its network router and collects the processor's outgoing packets. The processor cannot issue a 16-bit packet in one go. It sends two byte commands through one command port. The first command carries the destination, a 4-bit x coordinate in the upper nibble and a 4-bit y coordinate in the lower nibble. The second command carries the payload byte. The assembler keeps the destination until the payload arrives. It then writes the complete 16-bit packet into a small FIFO. The FIFO never holds a half-built packet.

The router works in fixed two-cycle slots that begin on the first clock edge after reset. At the start of a slot, if the router grants the slot and the FIFO holds a packet, the block pops one packet. It sends the destination byte in the first cycle of the slot and the payload byte in the second. The block reports full and empty status. A sticky flag records any packet lost because the FIFO was full.

Top module: `pkt_pair_queue`

## Requirements
- R1: After reset, `q_empty` is 1, `q_full` is 0, `overflow` is 0 and `tx_valid` is 0.
- R2: A command with `cmd_sel`=1 (destination) followed by a command with `cmd_sel`=0 (payload) enqueues one packet. The destination is the upper byte and the payload is the lower byte. The packet later leaves with exactly those two bytes.
- R3: A payload command (`cmd_sel`=0) while no destination is pending is ignored and enqueues nothing.
- R4: A second destination command while one is already pending replaces the stored destination. The packet then carries the later destination.
- R5: Each packet leaves over two consecutive cycles. The first cycle has `tx_valid`=1, `tx_is_dest`=1 and the destination byte. The second has `tx_valid`=1, `tx_is_dest`=0 and the payload byte. `tx_valid` is 0 in every other cycle.
- R6: A pop happens only at a slot start (even cycles counted from reset release), only while `slot_grant` is 1 and only while the FIFO is non-empty. Packets leave in the order they were completed.
- R7: The FIFO holds `DEPTH` (default 4) packets. `q_full` is 1 exactly when it holds `DEPTH` packets, and `q_empty` is 1 exactly when it holds none.
- R8: A packet completed while the FIFO is full is dropped and sets `overflow`. `overflow` then stays 1 until reset.
- R9: Asserting reset during operation discards every queued packet and any pending destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Processor command strobe |
| cmd_sel | input | 1 | 1 = destination byte, 0 = payload byte |
| cmd_data | input | 8 | Command byte |
| slot_grant | input | 1 | Router allows a packet to start in this slot |
| tx_valid | output | 1 | Router byte is valid |
| tx_is_dest | output | 1 | Router byte is the destination byte |
| tx_byte | output | 8 | Byte towards the router |
| q_full | output | 1 | FIFO holds DEPTH packets |
| q_empty | output | 1 | FIFO holds no packets |
| overflow | output | 1 | Sticky: a completed packet was dropped |

## Verification
The assertions take several things for granted about the inputs. Reset is released only after at least one clock edge. `cmd_sel` and `cmd_data` carry meaning only while `cmd_valid` is high. `slot_grant` may change in any cycle, because the block samples it only at a slot start. The stimulus drives every input on the falling edge and holds it for a full cycle. Each command is followed by one idle cycle. `slot_grant` is held low while the FIFO is being filled towards full, which is what makes the overflow and ordering cases reachable. A monitor pairs each destination byte with the following payload byte and compares the pair with the scoreboard queue.

// File: rtl/pqa_pkg.sv
package pqa_pkg;
  localparam int BYTE_W = 8;
  localparam int COORD_W = BYTE_W / 2;

  typedef struct packed {
    logic [BYTE_W-1:0] dest;
    logic [BYTE_W-1:0] val;
  } pkt_t;
endpackage

// File: rtl/pqa_collector.sv
module pqa_collector
  import pqa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_sel,
  input  logic [BYTE_W-1:0] cmd_data,
  output logic              push,
  output pkt_t              push_pkt
);
  logic              pend_q, pend_d;
  logic [BYTE_W-1:0] loc_q;
  logic              loc_en;

  always_comb begin
    pend_d = pend_q;
    loc_en = 1'b0;
    push   = 1'b0;
    if (cmd_valid) begin
      if (cmd_sel) begin
        loc_en = 1'b1;
        pend_d = 1'b1;
      end else if (pend_q) begin
        push   = 1'b1;
        pend_d = 1'b0;
      end
    end
    push_pkt.dest = loc_q;
    push_pkt.val  = cmd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      loc_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (loc_en) loc_q <= cmd_data;
    end
  end
endmodule

// File: rtl/pqa_fifo.sv
module pqa_fifo
  import pqa_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  pkt_t wr_pkt,
  input  logic pop,
  output pkt_t rd_pkt,
  output logic full,
  output logic empty,
  output logic drop
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  pkt_t          mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_ok, rd_ok;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (cnt_q == CNT_FULL);
    empty    = (cnt_q == '0);
    wr_ok    = push && !full;
    rd_ok    = pop && !empty;
    drop     = push && full;
    wr_ptr_d = wr_ok ? bump(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = rd_ok ? bump(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_ok && !rd_ok) cnt_d = cnt_q + 1'b1;
    else if (rd_ok && !wr_ok) cnt_d = cnt_q - 1'b1;
    rd_pkt = mem[rd_ptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_ptr_q] <= wr_pkt;
  end
endmodule

// File: rtl/pqa_serializer.sv
module pqa_serializer
  import pqa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_grant,
  input  logic              empty,
  input  pkt_t              head,
  output logic              pop,
  output logic              tx_valid,
  output logic              tx_is_dest,
  output logic [BYTE_W-1:0] tx_byte
);
  logic              slot_q;
  logic              busy_q, busy_d;
  logic [BYTE_W-1:0] vbuf_q;
  logic              vld_d, dst_d;
  logic [BYTE_W-1:0] byte_d;

  always_comb begin
    pop    = !slot_q && slot_grant && !empty;
    busy_d = 1'b0;
    vld_d  = 1'b0;
    dst_d  = 1'b0;
    byte_d = '0;
    if (pop) begin
      busy_d = 1'b1;
      vld_d  = 1'b1;
      dst_d  = 1'b1;
      byte_d = head.dest;
    end else if (busy_q) begin
      vld_d  = 1'b1;
      byte_d = vbuf_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q     <= 1'b0;
      busy_q     <= 1'b0;
      vbuf_q     <= '0;
      tx_valid   <= 1'b0;
      tx_is_dest <= 1'b0;
      tx_byte    <= '0;
    end else begin
      slot_q     <= ~slot_q;
      busy_q     <= busy_d;
      if (pop) vbuf_q <= head.val;
      tx_valid   <= vld_d;
      tx_is_dest <= dst_d;
      tx_byte    <= byte_d;
    end
  end
endmodule

// File: rtl/pkt_pair_queue.sv
module pkt_pair_queue
  import pqa_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_sel,
  input  logic [BYTE_W-1:0] cmd_data,
  input  logic              slot_grant,
  output logic              tx_valid,
  output logic              tx_is_dest,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              q_full,
  output logic              q_empty,
  output logic              overflow
);
  logic push, pop, drop;
  pkt_t push_pkt, head;
  logic ovf_q, ovf_d;

  pqa_collector u_coll (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .push(push), .push_pkt(push_pkt)
  );

  pqa_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .wr_pkt(push_pkt), .pop(pop),
    .rd_pkt(head), .full(q_full), .empty(q_empty), .drop(drop)
  );

  pqa_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .slot_grant(slot_grant), .empty(q_empty),
    .head(head), .pop(pop), .tx_valid(tx_valid), .tx_is_dest(tx_is_dest),
    .tx_byte(tx_byte)
  );

  always_comb ovf_d = ovf_q | drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/pqa_checker.sv
module pqa_checker (
  input logic clk,
  input logic rst_n,
  input logic slot_grant,
  input logic tx_valid,
  input logic tx_is_dest,
  input logic q_full,
  input logic q_empty,
  input logic overflow
);
  a_r7_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(q_full && q_empty));

  a_r5_payload_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_is_dest) |=> (tx_valid && !tx_is_dest));

  a_r5_payload_after_dest: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_is_dest) |-> $past(tx_valid && tx_is_dest));

  a_r6_pop_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_is_dest) |-> !$past(q_empty));

  a_r6_pop_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_is_dest) |-> $past(slot_grant));

  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r8_ovf_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(q_full));
endmodule

bind pkt_pair_queue pqa_checker u_chk (
  .clk(clk), .rst_n(rst_n), .slot_grant(slot_grant), .tx_valid(tx_valid),
  .tx_is_dest(tx_is_dest), .q_full(q_full), .q_empty(q_empty),
  .overflow(overflow)
);

// File: tb/sim_pkt_pair_queue.sv
`timescale 1ns/1ps
module sim_pkt_pair_queue;
  logic       clk, rst_n, cmd_valid, cmd_sel, slot_grant;
  logic [7:0] cmd_data, tx_byte;
  logic       tx_valid, tx_is_dest, q_full, q_empty, overflow;

  int n_chk = 0, n_bad = 0;
  logic [15:0] expq[$];
  logic        mon_have = 1'b0;
  logic [7:0]  mon_loc = '0;

  pkt_pair_queue u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_sel(cmd_sel),
    .cmd_data(cmd_data), .slot_grant(slot_grant), .tx_valid(tx_valid),
    .tx_is_dest(tx_is_dest), .tx_byte(tx_byte), .q_full(q_full),
    .q_empty(q_empty), .overflow(overflow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pairs destination and payload bytes
  always @(negedge clk) begin
    if (!rst_n) mon_have <= 1'b0;
    else if (mon_have) begin
      chk(tx_valid && !tx_is_dest, "R5 payload cycle", {tx_valid, tx_is_dest}, 2'b10);
      if (expq.size() == 0) chk(0, "R6 unexpected packet", {mon_loc, tx_byte}, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk({mon_loc, tx_byte} == e, "R2 packet content/order", {mon_loc, tx_byte}, e);
      end
      mon_have <= 1'b0;
    end else if (tx_valid) begin
      if (!tx_is_dest) chk(0, "R5 payload without destination", tx_byte, 0);
      else begin
        mon_have <= 1'b1;
        mon_loc  <= tx_byte;
      end
    end
  end

  task automatic wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_sel = sel; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] loc, input logic [7:0] v, input bit keep);
    wr(1'b1, loc);
    wr(1'b0, v);
    if (keep) expq.push_back({loc, v});
  endtask

  task automatic drain();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (expq.size() == 0 && !mon_have) break;
    end
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R6 all packets delivered", expq.size(), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    expq.delete();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_sel = 1'b0; cmd_data = '0; slot_grant = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(q_empty && !q_full && !overflow && !tx_valid, "R1 reset state",
        {q_empty, q_full, overflow, tx_valid}, 4'b1000);

    // R2/R5: basic packets, granted
    slot_grant = 1'b1;
    send(8'h45, 8'h0A, 1);
    send(8'h12, 8'h77, 1);
    drain();

    // R3: payload with nothing pending
    slot_grant = 1'b0;
    wr(1'b0, 8'h33);
    chk(q_empty, "R3 stray payload ignored", q_empty, 1);
    repeat (4) @(negedge clk);
    chk(!tx_valid && q_empty, "R3 no output", tx_valid, 0);

    // R4: second destination replaces first
    wr(1'b1, 8'h21);
    wr(1'b1, 8'h34);
    wr(1'b0, 8'h99);
    expq.push_back(16'h3499);
    chk(!q_empty, "R4 packet queued", q_empty, 0);
    slot_grant = 1'b1;
    drain();

    // R6: no pop without grant
    slot_grant = 1'b0;
    send(8'h5C, 8'hE1, 1);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(!tx_valid, "R6 held without grant", tx_valid, 0);
    end
    slot_grant = 1'b1;
    drain();

    // R7/R8: fill, overflow, sticky flag
    slot_grant = 1'b0;
    send(8'h11, 8'hA1, 1);
    send(8'h22, 8'hB2, 1);
    send(8'h33, 8'hC3, 1);
    chk(!q_full && !q_empty, "R7 three held", {q_full, q_empty}, 2'b00);
    send(8'h44, 8'hD4, 1);
    chk(q_full && !overflow, "R7 full at depth", {q_full, overflow}, 2'b10);
    send(8'h66, 8'hEE, 0);
    chk(q_full && overflow, "R8 drop sets overflow", {q_full, overflow}, 2'b11);
    slot_grant = 1'b1;
    drain();
    chk(q_empty && !q_full, "R7 empty after drain", {q_empty, q_full}, 2'b10);
    chk(overflow, "R8 overflow sticky", overflow, 1);

    // R9: reset mid-operation
    slot_grant = 1'b0;
    send(8'h71, 8'h01, 1);
    send(8'h72, 8'h02, 1);
    wr(1'b1, 8'h55);
    do_reset();
    chk(q_empty && !overflow, "R9 reset clears queue and flag", {q_empty, overflow}, 2'b10);
    wr(1'b0, 8'h66);
    chk(q_empty, "R9 pending destination cleared", q_empty, 1);
    slot_grant = 1'b1;
    repeat (6) @(negedge clk);
    chk(!tx_valid, "R9 nothing sent", tx_valid, 0);

    // R2/R6: steady stream with grant
    for (int i = 0; i < 6; i++) send(8'(8'h80 + i), 8'(8'h10 * i + 3), 1);
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule